// File: doc/BRIEF.md
# Wear-Weighted Trellis Coset Selector

This block picks, for each page segment, a codeword of a four-state rate 1/2 binary convolutional code that lies as close as possible to a target vector. The target is formed outside the block as the present memory contents XORed with the initial coset representative of the data word. The block returns the chosen codeword and the XOR of target and codeword. That XOR is the vector actually programmed into the cells, so a good choice means few cell writes.

Closeness is not plain Hamming distance. Each code bit arrives together with the number of times its cell has already been written. A mismatch costs more on a worn cell, and costs a prohibitive amount on a cell that has reached its last level. The result is that writes move toward fresh cells and wear stays even across the page.

Stages stream in over a valid/ready handshake, one stage per transfer. A stage carries two target bits, two 3-bit write counts and a page-end flag. Add-compare-select runs on the four trellis states, and each state keeps a fixed-depth window of survivor labels. Symbols leave the block a fixed window depth after they enter. At the page end the window of the best final state is drained in order.

Top module: `coset_wear_viterbi`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A mismatch on code bit i of a stage costs 1 + w, where w is that bit's write count, when w is below 7. It costs 4095 when w equals 7. Path metrics are 12-bit saturating sums of these costs, and after every stage the smallest of the four metrics is subtracted from all four.
- R3: With all write counts 0, the chosen codeword is the one at least Hamming distance from the target. A target that is itself a codeword yields out_write of all zeros on every stage.
- R4: The state is {u(t-1), u(t-2)}. Input bit u moves the trellis to state {u, u(t-1)}. Code bit 0 is u^u(t-1)^u(t-2) and code bit 1 is u^u(t-2), and in_target, in_wear0/in_wear1, out_code and out_write use this same bit order. All four start states have metric 0, and the final choice is the state with the lowest metric, with the lowest index winning a tie.
- R5: When the two candidate metrics into a state are equal, the predecessor with u(t-2)=0 is kept.
- R6: On every output symbol, out_write equals the target of that stage XOR out_code. Symbols leave in the order their stages entered.
- R7: The survivor window holds DEPTH=48 stages. A page of at most 48 stages gives the optimum over the whole page, and none of its symbols appears before its last stage is accepted. In a longer page, stage t is emitted when stage t+48 is accepted.
- R8: Exactly one symbol per input stage is produced, and out_last is 1 only on the page's final symbol. After that symbol all metrics return to 0, so the next page starts fresh.
- R9: While out_valid is 1 and out_ready is 0, the output symbol and out_last hold steady and in_ready is 0. in_ready is also 0 while the window of a finished page is being drained.
- R10: Consider a page in which each stage has at most one cell at count 7 and every other count is below 7. On such a page, no cell at count 7 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stage offered |
| in_ready | output | 1 | Stage accepted this cycle when high with in_valid |
| in_target | input | 2 | Target bits of the stage (bit 0 = first code bit) |
| in_wear0 | input | 3 | Prior write count of the cell for code bit 0 |
| in_wear1 | input | 3 | Prior write count of the cell for code bit 1 |
| in_last | input | 1 | Stage is the last of the page |
| out_valid | output | 1 | Output symbol present |
| out_ready | input | 1 | Consumer takes the symbol |
| out_code | output | 2 | Chosen codeword bits of the stage |
| out_write | output | 2 | Bits to program: target XOR codeword |
| out_last | output | 1 | Symbol is the final one of the page |

## Verification
Some properties are checked on every cycle. These are output holding under backpressure, the input stalling during stalls and drains, the guarantee that one normalized metric is always zero, and the bound on the window fill. Which codeword is chosen can only be shown by the bench's scenarios. These compare whole pages against an independent metric-and-traceback model and cover zero wear, random wear, sparse saturation, window-length boundaries, long pages and output backpressure.

// File: rtl/coset_pkg.sv
`timescale 1ns/1ps
package coset_pkg;
    localparam int unsigned NST = 4;

    // Edge label {bit1, bit0} entering state ns = {u, u1} from predecessor {u1, x}
    function automatic logic [1:0] edge_label(input logic [1:0] ns, input logic x);
        logic u;
        logic u1;
        u  = ns[1];
        u1 = ns[0];
        return {u ^ x, u ^ u1 ^ x};
    endfunction
endpackage

// File: rtl/coset_bmu.sv
`timescale 1ns/1ps
module coset_bmu #(
    parameter int unsigned PM_W   = 12,
    parameter int unsigned WEAR_W = 3
) (
    input  logic [1:0]            tgt,
    input  logic [WEAR_W-1:0]     wear0,
    input  logic [WEAR_W-1:0]     wear1,
    output logic [3:0][PM_W:0]    bm
);
    localparam logic [PM_W-1:0]   PM_MAX   = '1;
    localparam logic [WEAR_W-1:0] WEAR_SAT = '1;

    logic [PM_W-1:0] w0;
    logic [PM_W-1:0] w1;

    always_comb begin
        w0 = (wear0 == WEAR_SAT) ? PM_MAX : PM_W'(wear0) + PM_W'(1);
        w1 = (wear1 == WEAR_SAT) ? PM_MAX : PM_W'(wear1) + PM_W'(1);
    end

    for (genvar l = 0; l < 4; l++) begin : g_lbl
        localparam logic [1:0] LBL = 2'(l);
        assign bm[l] = ((tgt[0] != LBL[0]) ? {1'b0, w0} : {(PM_W+1){1'b0}})
                     + ((tgt[1] != LBL[1]) ? {1'b0, w1} : {(PM_W+1){1'b0}});
    end
endmodule

// File: rtl/coset_acs.sv
`timescale 1ns/1ps
module coset_acs #(
    parameter int unsigned PM_W = 12
) (
    input  logic [PM_W-1:0] pm_a,
    input  logic [PM_W-1:0] pm_b,
    input  logic [PM_W:0]   bm_a,
    input  logic [PM_W:0]   bm_b,
    output logic            pick_b,
    output logic [PM_W-1:0] pm_new
);
    localparam logic [PM_W-1:0] PM_MAX     = '1;
    localparam logic [PM_W+1:0] PM_MAX_EXT = {2'b00, PM_MAX};

    logic [PM_W+1:0] sum_a;
    logic [PM_W+1:0] sum_b;
    logic [PM_W-1:0] cap_a;
    logic [PM_W-1:0] cap_b;

    always_comb begin
        sum_a  = {2'b00, pm_a} + {1'b0, bm_a};
        sum_b  = {2'b00, pm_b} + {1'b0, bm_b};
        cap_a  = (sum_a > PM_MAX_EXT) ? PM_MAX : sum_a[PM_W-1:0];
        cap_b  = (sum_b > PM_MAX_EXT) ? PM_MAX : sum_b[PM_W-1:0];
        pick_b = (cap_b < cap_a);
        pm_new = pick_b ? cap_b : cap_a;
    end
endmodule

// File: rtl/coset_argmin.sv
`timescale 1ns/1ps
module coset_argmin #(
    parameter int unsigned VAL_W = 12,
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][VAL_W-1:0] val,
    output logic [IDX_W-1:0]        idx,
    output logic [VAL_W-1:0]        vmin
);
    always_comb begin
        vmin = val[0];
        idx  = '0;
        for (int i = 1; i < N; i++) begin
            if (val[i] < vmin) begin
                vmin = val[i];
                idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/coset_wear_viterbi.sv
`timescale 1ns/1ps
module coset_wear_viterbi
    import coset_pkg::*;
#(
    parameter int unsigned PM_W   = 12,
    parameter int unsigned WEAR_W = 3,
    parameter int unsigned DEPTH  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_target,
    input  logic [WEAR_W-1:0] in_wear0,
    input  logic [WEAR_W-1:0] in_wear1,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_code,
    output logic [1:0]        out_write,
    output logic              out_last
);
    localparam int unsigned     CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef enum logic {MODE_RUN = 1'b0, MODE_FLUSH = 1'b1} mode_e;

    typedef struct packed {
        mode_e                          mode;
        logic [NST-1:0][PM_W-1:0]       pm;
        logic [CNT_W-1:0]               fill;
        logic [1:0]                     fl_state;
        logic [NST-1:0][DEPTH-1:0][1:0] path;
        logic [DEPTH-1:0][1:0]          tdl;
        logic                           out_vld;
        logic [1:0]                     out_code;
        logic [1:0]                     out_write;
        logic                           out_last;
    } st_t;

    st_t st_q;
    st_t st_d;

    logic [3:0][PM_W:0]             bm;
    logic [NST-1:0]                 dec;
    logic [NST-1:0][PM_W-1:0]       nm;
    logic [NST-1:0][1:0]            lbl_sel;
    logic [NST-1:0][DEPTH-1:0][1:0] path_nx;
    logic [1:0]                     best_ns;
    logic [PM_W-1:0]                nm_min;
    logic [1:0]                     pbest;
    logic [1:0]                     em_code;
    logic [CNT_W-1:0]               fl_idx;
    logic                           accept;

    logic [NST-1:0][PM_W-1:0]       pm_cur;
    logic [CNT_W-1:0]               fill_cur;

    coset_bmu #(.PM_W(PM_W), .WEAR_W(WEAR_W)) u_bmu (
        .tgt   (in_target),
        .wear0 (in_wear0),
        .wear1 (in_wear1),
        .bm    (bm)
    );

    for (genvar ns = 0; ns < NST; ns++) begin : g_state
        localparam logic [1:0] NS  = 2'(ns);
        localparam logic [1:0] P_A = {NS[0], 1'b0};
        localparam logic [1:0] P_B = {NS[0], 1'b1};
        localparam logic [1:0] L_A = edge_label(NS, 1'b0);
        localparam logic [1:0] L_B = edge_label(NS, 1'b1);

        coset_acs #(.PM_W(PM_W)) u_acs (
            .pm_a   (st_q.pm[P_A]),
            .pm_b   (st_q.pm[P_B]),
            .bm_a   (bm[L_A]),
            .bm_b   (bm[L_B]),
            .pick_b (dec[ns]),
            .pm_new (nm[ns])
        );

        assign lbl_sel[ns] = dec[ns] ? L_B : L_A;
        assign path_nx[ns] = dec[ns] ? {st_q.path[P_B][DEPTH-2:0], L_B}
                                     : {st_q.path[P_A][DEPTH-2:0], L_A};
    end

    coset_argmin #(.VAL_W(PM_W), .N(NST)) u_best (
        .val  (nm),
        .idx  (best_ns),
        .vmin (nm_min)
    );

    assign in_ready = (st_q.mode == MODE_RUN) && (!st_q.out_vld || out_ready);
    assign accept   = in_valid && in_ready;
    assign pbest    = {best_ns[0], dec[best_ns]};
    assign em_code  = st_q.path[pbest][DEPTH-1];
    assign fl_idx   = st_q.fill - ONE;

    always_comb begin
        st_d = st_q;
        if (out_ready) begin
            st_d.out_vld = 1'b0;
        end
        if (accept) begin
            for (int s = 0; s < NST; s++) begin
                st_d.pm[s] = nm[s] - nm_min;
            end
            st_d.path = path_nx;
            st_d.tdl  = {st_q.tdl[DEPTH-2:0], in_target};
            if (st_q.fill == FULL) begin
                st_d.out_vld   = 1'b1;
                st_d.out_code  = em_code;
                st_d.out_write = st_q.tdl[DEPTH-1] ^ em_code;
                st_d.out_last  = 1'b0;
            end else begin
                st_d.fill = st_q.fill + ONE;
            end
            if (in_last) begin
                st_d.mode     = MODE_FLUSH;
                st_d.fl_state = best_ns;
            end
        end else if (st_q.mode == MODE_FLUSH && (!st_q.out_vld || out_ready)) begin
            st_d.out_vld   = 1'b1;
            st_d.out_code  = st_q.path[st_q.fl_state][fl_idx];
            st_d.out_write = st_q.tdl[fl_idx] ^ st_q.path[st_q.fl_state][fl_idx];
            st_d.out_last  = (st_q.fill == ONE);
            st_d.fill      = fl_idx;
            if (st_q.fill == ONE) begin
                st_d.mode = MODE_RUN;
                st_d.pm   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_vld;
    assign out_code  = st_q.out_code;
    assign out_write = st_q.out_write;
    assign out_last  = st_q.out_last;
    assign pm_cur    = st_q.pm;
    assign fill_cur  = st_q.fill;
endmodule

// File: rtl/coset_wear_viterbi_chk.sv
`timescale 1ns/1ps
module coset_wear_viterbi_chk #(
    parameter int unsigned PM_W  = 12,
    parameter int unsigned DEPTH = 48,
    parameter int unsigned NS_N  = 4,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic                      in_last,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [1:0]                out_code,
    input logic [1:0]                out_write,
    input logic                      out_last,
    input logic [NS_N-1:0][PM_W-1:0] pm_cur,
    input logic [CNT_W-1:0]          fill_cur
);
    logic any_zero;
    always_comb begin
        any_zero = 1'b0;
        for (int i = 0; i < NS_N; i++) begin
            if (pm_cur[i] == '0) any_zero = 1'b1;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_write) && $stable(out_last)); // R9
    AST_STALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R9
    AST_DRAIN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |=> !in_ready); // R8
    AST_NORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        any_zero); // R2
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cur <= CNT_W'(DEPTH)); // R7
endmodule

bind coset_wear_viterbi coset_wear_viterbi_chk #(.PM_W(PM_W), .DEPTH(DEPTH), .NS_N(coset_pkg::NST)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .out_write (out_write),
    .out_last  (out_last),
    .pm_cur    (pm_cur),
    .fill_cur  (fill_cur)
);

// File: tb/tb_coset_wear_viterbi.sv
`timescale 1ns/1ps
module tb_coset_wear_viterbi;
    localparam int DEPTH = 48;
    localparam int MAXN  = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_target = 2'b00;
    logic [2:0] in_wear0 = 3'd0;
    logic [2:0] in_wear1 = 3'd0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [1:0] out_code;
    logic [1:0] out_write;
    logic       out_last;

    always #2.5 clk = ~clk;

    coset_wear_viterbi #(.PM_W(12), .WEAR_W(3), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_target(in_target), .in_wear0(in_wear0), .in_wear1(in_wear1),
        .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_code(out_code), .out_write(out_write), .out_last(out_last)
    );

    int total = 0;
    int bad = 0;

    bit [1:0] tg [MAXN];
    bit [2:0] w0 [MAXN];
    bit [2:0] w1 [MAXN];
    bit [1:0] ex [MAXN];
    bit [1:0] oc [MAXN];
    bit [1:0] ow [MAXN];
    bit       ol [MAXN];
    int       n_out = 0;
    bit       bp_mode = 1'b0;
    bit [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output monitor and backpressure driver
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_mode ? lfsr[0] : 1'b1;
        if (rst_n && out_valid && out_ready && n_out < MAXN) begin
            oc[n_out] = out_code;
            ow[n_out] = out_write;
            ol[n_out] = out_last;
            n_out++;
        end
    end

    function automatic int wt(input bit [2:0] w);
        return (w == 3'd7) ? 4095 : int'(w) + 1;
    endfunction

    function automatic bit [1:0] lab(input int ns, input int x);
        bit u, u1, xb;
        u  = ns[1];
        u1 = ns[0];
        xb = x[0];
        return {u ^ xb, u ^ u1 ^ xb};
    endfunction

    // Independent full-page model: weighted metric, saturation, normalization, tie rules, traceback
    task automatic model(input int n);
        int pm [4];
        int pmn [4];
        bit dc [MAXN][4];
        int mn, best, s, x;
        for (int i = 0; i < 4; i++) pm[i] = 0;
        for (int t = 0; t < n; t++) begin
            for (int ns = 0; ns < 4; ns++) begin
                int sa, sb;
                bit [1:0] la, lb;
                la = lab(ns, 0);
                lb = lab(ns, 1);
                sa = pm[(ns % 2) * 2] + ((tg[t][0] != la[0]) ? wt(w0[t]) : 0) + ((tg[t][1] != la[1]) ? wt(w1[t]) : 0);
                sb = pm[(ns % 2) * 2 + 1] + ((tg[t][0] != lb[0]) ? wt(w0[t]) : 0) + ((tg[t][1] != lb[1]) ? wt(w1[t]) : 0);
                if (sa > 4095) sa = 4095;
                if (sb > 4095) sb = 4095;
                dc[t][ns] = (sb < sa);
                pmn[ns] = (sb < sa) ? sb : sa;
            end
            mn = pmn[0];
            for (int i = 1; i < 4; i++) if (pmn[i] < mn) mn = pmn[i];
            for (int i = 0; i < 4; i++) pm[i] = pmn[i] - mn;
        end
        best = 0;
        for (int i = 3; i >= 0; i--) if (pm[i] <= pm[best]) best = i;
        s = best;
        for (int t = n - 1; t >= 0; t--) begin
            x = int'(dc[t][s]);
            ex[t] = lab(s, x);
            s = (s % 2) * 2 + x;
        end
    endtask

    task automatic send(input int n, input bit early_chk);
        for (int t = 0; t < n; t++) begin
            do begin
                @(negedge clk);
                in_valid  = 1'b1;
                in_target = tg[t];
                in_wear0  = w0[t];
                in_wear1  = w1[t];
                in_last   = (t == n - 1);
                #1;
            end while (!in_ready);
            if (early_chk && t == n - 1)
                chk(n_out == 0, "R7 no symbol before page end", n_out, 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_page(input int n, input bit exact, input string req);
        int errs, lasts, wbad;
        n_out = 0;
        if (exact) model(n);
        send(n, exact && n <= DEPTH);
        for (int c = 0; c < 2000 && n_out < n; c++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(n_out == n, "R8 symbol count", n_out, n);
        lasts = 0;
        for (int t = 0; t < n_out; t++) if (ol[t]) lasts++;
        chk(lasts == 1 && ol[n - 1], "R8 single last on final symbol", lasts, 1);
        wbad = 0;
        for (int t = 0; t < n; t++) if (ow[t] != (tg[t] ^ oc[t])) wbad++;
        chk(wbad == 0, "R6 write equals target xor code", wbad, 0);
        if (exact) begin
            errs = 0;
            for (int t = 0; t < n; t++) begin
                if (oc[t] != ex[t]) begin
                    errs++;
                    if (errs == 1) $display("FAIL %s stage %0d actual=%0d expected=%0d", req, t, oc[t], ex[t]);
                end
            end
            total++;
            if (errs != 0) bad++;
        end
    endtask

    task automatic fill_rand(input int n, input int wmax, input bit sat);
        for (int t = 0; t < n; t++) begin
            tg[t] = 2'($urandom_range(0, 3));
            w0[t] = 3'($urandom_range(0, wmax));
            w1[t] = 3'($urandom_range(0, wmax));
            if (sat && $urandom_range(0, 1) == 1) begin
                if ($urandom_range(0, 1) == 1) w0[t] = 3'd7;
                else w1[t] = 3'd7;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

        // R3: zero wear, nearest codeword in Hamming distance
        fill_rand(20, 0, 1'b0);
        run_page(20, 1'b1, "R3 zero-wear nearest codeword");

        // R5 / R4: tie-heavy zero-wear short pages
        for (int k = 1; k <= 4; k++) begin
            fill_rand(k, 0, 1'b0);
            run_page(k, 1'b1, "R5 tie choice");
        end

        // R2 / R4: random wear, lengths up to the window depth
        for (int k = 0; k < 6; k++) begin
            int n;
            n = (k == 5) ? DEPTH : 5 + k * 8;
            fill_rand(n, 6, 1'b0);
            run_page(n, 1'b1, "R2 wear-weighted choice");
        end

        // R10: sparse saturated cells are avoided
        for (int k = 0; k < 3; k++) begin
            int hits;
            fill_rand(30, 6, 1'b1);
            run_page(30, 1'b1, "R10 saturated page model");
            hits = 0;
            for (int t = 0; t < 30; t++) begin
                if (w0[t] == 3'd7 && ow[t][0]) hits++;
                if (w1[t] == 3'd7 && ow[t][1]) hits++;
            end
            chk(hits == 0, "R10 saturated cell written", hits, 0);
        end

        // R9: backpressure on the output
        bp_mode = 1'b1;
        fill_rand(45, 6, 1'b0);
        run_page(45, 1'b1, "R9 backpressure page");
        bp_mode = 1'b0;

        // R3 / R7: long page whose target is a codeword
        begin
            bit u1, u2, u;
            int zw, cm;
            u1 = 1'($urandom_range(0, 1));
            u2 = 1'($urandom_range(0, 1));
            for (int t = 0; t < 130; t++) begin
                u = 1'($urandom_range(0, 1));
                tg[t] = {u ^ u2, u ^ u1 ^ u2};
                w0[t] = 3'd0;
                w1[t] = 3'd0;
                u2 = u1;
                u1 = u;
            end
            run_page(130, 1'b0, "R7");
            zw = 0;
            cm = 0;
            for (int t = 0; t < 130; t++) begin
                if (ow[t] != 2'b00) zw++;
                if (oc[t] != tg[t]) cm++;
            end
            chk(zw == 0, "R3 codeword target writes nothing", zw, 0);
            chk(cm == 0, "R7 long page code matches target", cm, 0);
        end

        // R6 / R8: long random page with backpressure
        bp_mode = 1'b1;
        fill_rand(100, 6, 1'b0);
        run_page(100, 1'b0, "R6");
        bp_mode = 1'b0;

        // R8: fresh start after a long page
        fill_rand(33, 6, 1'b0);
        run_page(33, 1'b1, "R8 restart after page");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule